// File: doc/BRIEF.md
# Multichannel Serial Audio Frame Shifter

This block moves PCM samples between a parallel stream and a single serial data wire. It works in one direction at a time. In transmit it accepts samples over a valid/ready handshake, places each one in its time slot and shifts it out MSB first. In receive it gathers the bits of each slot and returns them as a right-aligned sample on a valid/ready output. Bit timing comes from outside the block: a one-cycle pulse `bit_stb` marks each bit period and `ws` carries the word-select level. At each pulse the block presents its next transmit bit on `sd_out` and samples `sd_in`.

A frame is two word-select halves. Half of the configured channels travel in each half. The number of bits in a half (the system word length) is set on its own, apart from the sample depth. This lets samples sit inside wider fixed slots, as time-division-multiplexed codecs expect. Each half is split evenly into slots, one per channel. The ordering options cover standard one-bit-delayed framing, left-justified framing and right-justified framing. Frames begin on a falling `ws`, so channel 0 is in the low half.

Top module: `ssf_frame_shifter`

## Requirements
- R1: With `cfg_tx`=1 the block drives `sd_oe` high, consumes input samples and never raises `m_valid`. With `cfg_tx`=0, `sd_oe` stays low, `s_ready` is never asserted, and slots are captured from `sd_in`.
- R2: `cfg_chan` holds channels/2 − 1 (0..3 for 2, 4, 6, 8 channels). Each half-frame holds cfg_chan+1 slots of equal length, half-frame bits divided by cfg_chan+1. One input sample is taken at the first bit of every such slot, in order.
- R3: `cfg_dwl` selects the sample depth: 0→8, 1→16, 2→18, 3→20, 4→22, 5→24, 6→32 bits. Input samples are right-aligned in `s_data`, and bits above the depth are ignored.
- R4: `cfg_swl` selects the half-frame length: 0→8, 1→16, 2→32, 3→48, 4→64, 5→128, 6→256 bits. Slot bit times not covered by the sample are transmitted as 0.
- R5: Samples of 17 to 24 bits occupy a 24-bit container, whose low bits beyond the sample are padding. Other depths use a container equal to the depth.
- R6: With `cfg_nodelay`=0 the first bit of a half-frame is the bit period after the `ws` change. With `cfg_nodelay`=1 it is the bit period of the change itself. Nothing is transmitted or captured before the first falling `ws` after enable.
- R7: With `cfg_lsbjust`=0 the container starts at the first bit of its slot. With `cfg_lsbjust`=1 it ends at the last bit of its slot.
- R8: `cfg_mute`=1 drives 0 on every transmitted bit while slots and sample consumption continue.
- R9: With `cfg_en`=0, `sd_out` stays 0, no sample is accepted and none is delivered.
- R10: A transmit slot that starts with `s_valid` low carries zeros and sets the sticky `underrun` flag, which clears only on reset.
- R11: A received sample is delivered on `m_data` with its upper bits zero. Padding bit times on `sd_in` are ignored. `m_data` holds steady while `m_valid` is high and `m_ready` is low.
- R12: When a slot completes while the previous sample is still unaccepted, the new sample is dropped and the sticky `overrun` flag is set.
- R13: `sd_out` takes the bit of a strobe one clock after that strobe, and `m_valid` rises one clock after the strobe of a slot's last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Enable transfers |
| cfg_tx | input | 1 | 1 transmit, 0 receive |
| cfg_chan | input | 2 | Channels/2 − 1 |
| cfg_dwl | input | 3 | Sample depth code |
| cfg_swl | input | 3 | Half-frame length code |
| cfg_nodelay | input | 1 | 1: data starts on the ws change |
| cfg_lsbjust | input | 1 | 1: container at slot end |
| cfg_mute | input | 1 | Force transmit bits to zero |
| bit_stb | input | 1 | One pulse per bit period |
| ws | input | 1 | Word-select level |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Output enable for the data line |
| s_valid | input | 1 | Transmit sample valid |
| s_data | input | 32 | Transmit sample, right-aligned |
| s_ready | output | 1 | Transmit sample taken this cycle |
| m_valid | output | 1 | Received sample valid |
| m_data | output | 32 | Received sample, right-aligned |
| m_ready | input | 1 | Received sample accepted |
| underrun | output | 1 | Sticky transmit starvation flag |
| overrun | output | 1 | Sticky receive loss flag |

## Verification
Every transmit result appears on `sd_out` exactly one clock after the strobe that carries it. The bench drives strobes on a negative edge and compares `sd_out` on every later negative edge against a model value. That model value is refreshed only at strobes, so both hold and update cycles are covered. A received sample is due one clock after the strobe of its slot's last bit, and with `m_ready` high it is visible for exactly one negative edge. The bench compares it there, in slot order. Sample acceptance is seen in the same cycle as the strobe and is counted before the clock edge that completes it.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    localparam int SMP_W = 32;
    localparam int POS_W = 9;
    localparam int DW_W  = 6;

    function automatic logic [DW_W-1:0] depth_bits(input logic [2:0] code);
        case (code)
            3'd0:    return DW_W'(8);
            3'd1:    return DW_W'(16);
            3'd2:    return DW_W'(18);
            3'd3:    return DW_W'(20);
            3'd4:    return DW_W'(22);
            3'd5:    return DW_W'(24);
            default: return DW_W'(32);
        endcase
    endfunction

    function automatic logic [POS_W-1:0] half_bits(input logic [2:0] code);
        case (code)
            3'd0:    return POS_W'(8);
            3'd1:    return POS_W'(16);
            3'd2:    return POS_W'(32);
            3'd3:    return POS_W'(48);
            3'd4:    return POS_W'(64);
            3'd5:    return POS_W'(128);
            default: return POS_W'(256);
        endcase
    endfunction

    // container width: 17..24-bit samples ride in 24 bits
    function automatic logic [DW_W-1:0] box_bits(input logic [DW_W-1:0] w);
        return (w > DW_W'(16) && w <= DW_W'(24)) ? DW_W'(24) : w;
    endfunction

endpackage

// File: rtl/ssf_timing.sv
module ssf_timing #(
    parameter int POS_W = ssf_pkg::POS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bit_stb,
    input  logic             ws,
    input  logic             cfg_nodelay,
    input  logic [POS_W-1:0] slot_len,
    input  logic [2:0]       half_slots,
    output logic             stb_o,
    output logic             in_slot_o,
    output logic [POS_W-1:0] pos_o
);

    typedef struct packed {
        logic             ws;
        logic             chg_seen;
        logic             synced;
        logic [POS_W-1:0] pos;
        logic [2:0]       idx;
    } tim_t;

    tim_t tim_d, tim_q;
    logic ws_chg, hf_start;

    always_comb begin
        tim_d     = tim_q;
        stb_o     = 1'b0;
        in_slot_o = 1'b0;
        pos_o     = tim_q.pos;
        ws_chg    = ws ^ tim_q.ws;
        hf_start  = cfg_nodelay ? ws_chg : tim_q.chg_seen;
        if (bit_stb) begin
            tim_d.ws       = ws;
            tim_d.chg_seen = ws_chg;
            if (hf_start && !ws)
                tim_d.synced = 1'b1;
            if (hf_start) begin
                tim_d.pos = '0;
                tim_d.idx = '0;
            end else if (tim_q.pos == slot_len - POS_W'(1)) begin
                tim_d.pos = '0;
                if (tim_q.idx != 3'd7)
                    tim_d.idx = tim_q.idx + 3'd1;
            end else begin
                tim_d.pos = tim_q.pos + POS_W'(1);
            end
        end
        if (!en)
            tim_d.synced = 1'b0;
        if (bit_stb) begin
            stb_o     = en && tim_d.synced;
            in_slot_o = tim_d.idx < half_slots;
            pos_o     = tim_d.pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tim_q <= '0;
        else        tim_q <= tim_d;
    end

    // R6: no bit activity until a half-frame start has been seen after enable
    a_r6_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && !tim_q.synced) |-> (hf_start && !ws));

endmodule

// File: rtl/ssf_tx.sv
module ssf_tx #(
    parameter int SMP_W = ssf_pkg::SMP_W,
    parameter int POS_W = ssf_pkg::POS_W,
    parameter int DW_W  = ssf_pkg::DW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stb,
    input  logic             in_slot,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] slot_len,
    input  logic [DW_W-1:0]  dwl,
    input  logic [DW_W-1:0]  box,
    input  logic             cfg_lsbjust,
    input  logic             cfg_mute,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_data,
    output logic             s_ready,
    output logic             sd_out,
    output logic             underrun
);

    localparam int KW = $clog2(SMP_W);

    typedef struct packed {
        logic [SMP_W-1:0] hold;
        logic             sd;
        logic             unf;
    } tx_t;

    tx_t tx_d, tx_q;
    logic [SMP_W-1:0] word, shw;
    logic [POS_W-1:0] off, k;
    logic             take, nbit;

    always_comb begin
        tx_d    = tx_q;
        s_ready = 1'b0;
        word    = tx_q.hold;
        take    = active && stb && in_slot && (pos == '0);
        if (take) begin
            s_ready = 1'b1;
            if (s_valid) begin
                word = s_data << (DW_W'(SMP_W) - dwl);
            end else begin
                word       = '0;
                tx_d.unf   = 1'b1;
            end
            tx_d.hold = word;
        end
        off  = cfg_lsbjust ? (slot_len - POS_W'(box)) : '0;
        k    = pos - off;
        shw  = word << k[KW-1:0];
        nbit = in_slot && (pos >= off) && (k < POS_W'(dwl)) && !cfg_mute && shw[SMP_W-1];
        if (!active)  tx_d.sd = 1'b0;
        else if (stb) tx_d.sd = nbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sd_out   = tx_q.sd;
    assign underrun = tx_q.unf;

    a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_mute) && $past(stb)) |-> !sd_out);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> !sd_out);
    a_r10_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(underrun) |-> underrun);
    a_r2_one_take: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

endmodule

// File: rtl/ssf_rx.sv
module ssf_rx #(
    parameter int SMP_W = ssf_pkg::SMP_W,
    parameter int POS_W = ssf_pkg::POS_W,
    parameter int DW_W  = ssf_pkg::DW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stb,
    input  logic             in_slot,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] slot_len,
    input  logic [DW_W-1:0]  dwl,
    input  logic [DW_W-1:0]  box,
    input  logic             cfg_lsbjust,
    input  logic             sd_in,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [SMP_W-1:0] m_data,
    output logic             overrun
);

    typedef struct packed {
        logic [SMP_W-1:0] sh;
        logic             mv;
        logic [SMP_W-1:0] md;
        logic             ovf;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [SMP_W-1:0] base;
    logic [POS_W-1:0] off, k;

    always_comb begin
        rx_d = rx_q;
        base = rx_q.sh;
        off  = cfg_lsbjust ? (slot_len - POS_W'(box)) : '0;
        k    = pos - off;
        if (rx_q.mv && m_ready)
            rx_d.mv = 1'b0;
        if (active && stb && in_slot) begin
            if (pos == '0) base = '0;
            if ((pos >= off) && (k < POS_W'(dwl)))
                rx_d.sh = {base[SMP_W-2:0], sd_in};
            else
                rx_d.sh = base;
            if (pos == slot_len - POS_W'(1)) begin
                if (rx_q.mv && !m_ready) begin
                    rx_d.ovf = 1'b1;
                end else begin
                    rx_d.mv = 1'b1;
                    rx_d.md = rx_d.sh;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign m_valid = rx_q.mv;
    assign m_data  = rx_q.md;
    assign overrun = rx_q.ovf;

    a_r11_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun);

endmodule

// File: rtl/ssf_frame_shifter.sv
module ssf_frame_shifter #(
    parameter int SMP_W = ssf_pkg::SMP_W,
    parameter int POS_W = ssf_pkg::POS_W,
    parameter int DW_W  = ssf_pkg::DW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_tx,
    input  logic [1:0]       cfg_chan,
    input  logic [2:0]       cfg_dwl,
    input  logic [2:0]       cfg_swl,
    input  logic             cfg_nodelay,
    input  logic             cfg_lsbjust,
    input  logic             cfg_mute,
    input  logic             bit_stb,
    input  logic             ws,
    input  logic             sd_in,
    output logic             sd_out,
    output logic             sd_oe,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_data,
    output logic             s_ready,
    output logic             m_valid,
    output logic [SMP_W-1:0] m_data,
    input  logic             m_ready,
    output logic             underrun,
    output logic             overrun
);

    import ssf_pkg::*;

    logic [2:0]       half_slots;
    logic [POS_W-1:0] slot_len;
    logic [DW_W-1:0]  dwl, box;
    logic             stb, in_slot;
    logic [POS_W-1:0] pos;

    always_comb begin
        half_slots = {1'b0, cfg_chan} + 3'd1;
        slot_len   = POS_W'(half_bits(cfg_swl) / POS_W'(half_slots));
        dwl        = depth_bits(cfg_dwl);
        box        = box_bits(dwl);
    end

    assign sd_oe = cfg_en & cfg_tx;

    ssf_timing #(.POS_W(POS_W)) i_timing (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .bit_stb(bit_stb), .ws(ws),
        .cfg_nodelay(cfg_nodelay), .slot_len(slot_len), .half_slots(half_slots),
        .stb_o(stb), .in_slot_o(in_slot), .pos_o(pos)
    );

    ssf_tx #(.SMP_W(SMP_W), .POS_W(POS_W), .DW_W(DW_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .active(cfg_en & cfg_tx), .stb(stb),
        .in_slot(in_slot), .pos(pos), .slot_len(slot_len), .dwl(dwl), .box(box),
        .cfg_lsbjust(cfg_lsbjust), .cfg_mute(cfg_mute), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .sd_out(sd_out), .underrun(underrun)
    );

    ssf_rx #(.SMP_W(SMP_W), .POS_W(POS_W), .DW_W(DW_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .active(cfg_en & ~cfg_tx), .stb(stb),
        .in_slot(in_slot), .pos(pos), .slot_len(slot_len), .dwl(dwl), .box(box),
        .cfg_lsbjust(cfg_lsbjust), .sd_in(sd_in), .m_ready(m_ready),
        .m_valid(m_valid), .m_data(m_data), .overrun(overrun)
    );

    a_r1_rx_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_tx |-> !s_ready);
    a_r1_tx_no_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_valid) |-> $past(cfg_en && !cfg_tx));
    a_r9_off_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !s_ready);

endmodule

// File: tb/test_ssf_frame_shifter.sv
`timescale 1ns/1ps
module test_ssf_frame_shifter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_tx = 1'b0;
    logic [1:0]  cfg_chan = '0;
    logic [2:0]  cfg_dwl = '0, cfg_swl = '0;
    logic        cfg_nodelay = 1'b0, cfg_lsbjust = 1'b0, cfg_mute = 1'b0;
    logic        bit_stb = 1'b0, ws = 1'b1, sd_in = 1'b0;
    logic        sd_out, sd_oe, s_ready, m_valid, underrun, overrun;
    logic        s_valid = 1'b0, m_ready = 1'b1;
    logic [31:0] s_data = '0, m_data;

    always #4 clk = ~clk;

    ssf_frame_shifter i_ssf_frame_shifter (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_tx(cfg_tx),
        .cfg_chan(cfg_chan), .cfg_dwl(cfg_dwl), .cfg_swl(cfg_swl),
        .cfg_nodelay(cfg_nodelay), .cfg_lsbjust(cfg_lsbjust), .cfg_mute(cfg_mute),
        .bit_stb(bit_stb), .ws(ws), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
        .underrun(underrun), .overrun(overrun)
    );

    int checks = 0, errors = 0, cycles = 0;
    int n_dwl, n_swl, n_box, n_len, n_cph, n_samp;
    bit b_nodelay, b_just, b_mute, b_en, b_tx, b_ready;
    logic [31:0] samp [0:127];
    int tx_idx, acc_cnt, rx_cnt, mv_seen, exp_sd;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected at most 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dmask(input int w);
        return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    endfunction

    // -1: padding or no slot, -2: slot beyond sample count lim, else data bit
    function automatic int slot_bit(input int q, input int lim);
        int h, p, j, n, k, off;
        if (q < 0) return -1;
        h = q / n_swl; p = q % n_swl; j = p / n_len;
        if (j >= n_cph) return -1;
        n   = h * n_cph + j;
        off = b_just ? (n_len - n_box) : 0;
        k   = p - j * n_len - off;
        if (k < 0 || k >= n_dwl) return -1;
        if (n >= lim) return -2;
        return int'(samp[n][n_dwl-1-k]);
    endfunction

    task automatic setup(input int ch, input int dwl, input int swl, input bit nodel,
                         input bit just, input bit mute, input bit en, input bit tx,
                         input bit rdy, input int nsamp, input int seed);
        n_dwl = dwl; n_swl = swl; n_cph = ch / 2; n_len = swl / n_cph;
        n_box = (dwl > 16 && dwl <= 24) ? 24 : dwl;
        b_nodelay = nodel; b_just = just; b_mute = mute; b_en = en; b_tx = tx;
        b_ready = rdy; n_samp = nsamp;
        for (int i = 0; i < 128; i++)
            samp[i] = ((i * 32'h9E37_79B1) ^ 32'h5A5A_1234 ^ seed) & dmask(dwl);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_chan = 2'(n_cph - 1);
        case (dwl) 8: cfg_dwl = 0; 16: cfg_dwl = 1; 18: cfg_dwl = 2; 20: cfg_dwl = 3;
                   22: cfg_dwl = 4; 24: cfg_dwl = 5; default: cfg_dwl = 6; endcase
        case (swl) 8: cfg_swl = 0; 16: cfg_swl = 1; 32: cfg_swl = 2; 48: cfg_swl = 3;
                   64: cfg_swl = 4; 128: cfg_swl = 5; default: cfg_swl = 6; endcase
        cfg_nodelay = nodel; cfg_lsbjust = just; cfg_mute = mute;
        cfg_en = en; cfg_tx = tx; m_ready = rdy;
        bit_stb = 1'b0; ws = 1'b1; s_valid = 1'b0;
        tx_idx = 0; acc_cnt = 0; rx_cnt = 0; mv_seen = 0; exp_sd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int frames, input string req);
        int v;
        for (int g = -n_swl; g < (2 * frames + 1) * n_swl; g++) begin
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                chk(sd_out == exp_sd[0], req, sd_out, exp_sd);
                if (m_valid) begin
                    mv_seen++;
                    if (b_ready) begin
                        chk(m_data == samp[rx_cnt], "R11", m_data, samp[rx_cnt]);
                        rx_cnt++;
                    end
                end
                bit_stb = (c == 0);
                ws = (g < 0) ? 1'b1 : 1'((g / n_swl) % 2);
                if (c == 0) begin
                    v = slot_bit(b_nodelay ? g : g - 1, n_samp);
                    exp_sd = (b_en && b_tx && !b_mute && v >= 0) ? v : 0;
                    v = slot_bit(b_nodelay ? g : g - 1, 128);
                    sd_in = (v >= 0) ? 1'(v) : 1'b1;
                end
                s_valid = (tx_idx < n_samp);
                s_data  = samp[tx_idx % 128] | (~dmask(n_dwl) & 32'hA5C3_96F0);
                #1;
                if (s_ready && s_valid) begin
                    tx_idx++;
                    acc_cnt++;
                end
            end
        end
        @(negedge clk);
        bit_stb = 1'b0;
        chk(sd_out == exp_sd[0], req, sd_out, exp_sd);
    endtask

    initial begin
        // reset state
        repeat (2) @(negedge clk);
        chk(sd_out == 1'b0, "R9", sd_out, 0);
        chk(sd_oe == 1'b0, "R1", sd_oe, 0);
        chk(m_valid == 1'b0, "R11", m_valid, 0);
        chk(underrun == 1'b0, "R10", underrun, 0);
        chk(overrun == 1'b0, "R12", overrun, 0);

        // R6 R13 R3: stereo, 16-bit in 16-bit halves, one-bit delay
        setup(2, 16, 16, 0, 0, 0, 1, 1, 1, 10, 1);
        chk(sd_oe == 1'b1, "R1", sd_oe, 1);
        run(2, "R6");
        chk(acc_cnt == 5 * 1 * 2 / 2, "R2", acc_cnt, 5);
        chk(underrun == 1'b0, "R10", underrun, 0);
        chk(mv_seen == 0, "R1", mv_seen, 0);

        // R3: 32-bit samples, delayed framing
        setup(2, 32, 32, 0, 0, 0, 1, 1, 1, 5, 2);
        run(2, "R3");

        // R2 R4: eight channels, 16-bit samples in 32-bit slots, no delay
        setup(8, 16, 128, 1, 0, 0, 1, 1, 1, 20, 3);
        run(2, "R4");
        chk(acc_cnt == 20, "R2", acc_cnt, 20);

        // R2: six channels in 48-bit halves
        setup(6, 16, 48, 0, 0, 0, 1, 1, 1, 15, 4);
        run(2, "R2");

        // R5 R7: 20-bit samples, 24-bit container right-justified in 32-bit slots
        setup(4, 20, 64, 1, 1, 0, 1, 1, 1, 10, 5);
        run(2, "R7");

        // R5: 18-bit samples, left-justified container
        setup(2, 18, 32, 1, 0, 0, 1, 1, 1, 5, 6);
        run(2, "R5");

        // R8: mute keeps consuming
        setup(4, 16, 32, 0, 0, 1, 1, 1, 1, 10, 7);
        run(2, "R8");
        chk(acc_cnt == 10, "R8", acc_cnt, 10);

        // R10: starvation
        setup(2, 16, 16, 0, 0, 0, 1, 1, 1, 1, 8);
        run(2, "R10");
        chk(underrun == 1'b1, "R10", underrun, 1);

        // R9: disabled
        setup(2, 16, 16, 0, 0, 0, 0, 1, 1, 5, 9);
        run(1, "R9");
        chk(acc_cnt == 0, "R9", acc_cnt, 0);
        chk(sd_oe == 1'b0, "R9", sd_oe, 0);

        // R11 R1: receive 24-bit stereo, padding lines driven high
        setup(2, 24, 32, 0, 0, 0, 1, 0, 1, 0, 10);
        chk(sd_oe == 1'b0, "R1", sd_oe, 0);
        run(2, "R1");
        chk(acc_cnt == 0, "R1", acc_cnt, 0);
        chk(rx_cnt >= 4, "R11", rx_cnt, 4);

        // R11 R7: receive 20-bit right-justified, four channels
        setup(4, 20, 64, 1, 1, 0, 1, 0, 1, 0, 11);
        run(2, "R11");
        chk(rx_cnt >= 8, "R11", rx_cnt, 8);

        // R12: nothing accepted
        setup(2, 16, 16, 1, 0, 0, 1, 0, 0, 0, 12);
        run(1, "R12");
        chk(m_valid == 1'b1, "R12", m_valid, 1);
        chk(m_data == samp[0], "R12", m_data, samp[0]);
        chk(overrun == 1'b1, "R12", overrun, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule